// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one external memory bus cycle at a time. Each bus cycle is split into four phases of one clock each, called Q1 to Q4. The block produces the pin-level timing for a bus that carries address and data on the same lines. In Q1 it pulses the address strobe and drives the low address bits. The remaining high address bits sit on a separate set of pins for the whole access. The active-low read strobe is held low from Q3 up to the end of the access. When the read strobe rises, the block captures the returned data and raises a one-clock completion flag.

There are two kinds of request. An instruction fetch returns a 16-bit word. A table read returns one byte. A configuration input selects between a 16-bit bus and an 8-bit bus. On the 8-bit bus, a fetch collects both bytes within one access by toggling the byte-address pin halfway through the read strobe. A table read can be lengthened by a programmable number of extra bus cycles. A bus-off input releases every pin driver and blocks new accesses.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it, `ale`=0, `oe_n`=1, `ad_drive`=0, `ba0`=0, `done`=0, `addr_hi`=0, and both result outputs are 0.
- R2: A request is accepted on a clock edge where `req_valid`=1, `bus_off`=0 and no access is running. The next clock is Q1. Only in Q1 does `ale`=1, and only then does `ad_out` carry `req_ptr[16:1]`. `ad_drive` is high only in Q1. `addr_hi` carries `req_ptr[20:17]` for the whole access and is 0 when the bus is idle.
- R3: `oe_n` is 0 from the third clock of an access through its last clock, and 1 at all other times. `oe_n` is never 0 while `ale` is 1.
- R4: A fetch lasts 4 clocks. On a 16-bit bus it returns `pad_din` as sampled in its last clock, and `ba0` stays 0. `done` is high for one clock right after the last clock of the access, at the moment `oe_n` rises.
- R5: A table read on a 16-bit bus returns `pad_din[7:0]` when `req_ptr[0]`=0 and `pad_din[15:8]` when `req_ptr[0]`=1.
- R6: A table read lasts 4*(1+n) clocks, where n = 3 - `cfg_wait`. So code 3 gives 0 extra cycles, 2 gives 1, 1 gives 2 and 0 gives 3. A fetch ignores `cfg_wait`.
- R7: A fetch on an 8-bit bus (`cfg_narrow`=1) holds `ba0`=0 in Q3 and `ba0`=1 in Q4. It takes the low result byte from `pad_din[7:0]` in Q3 and the high result byte from `pad_din[7:0]` in Q4.
- R8: During a table read, `ba0` equals `req_ptr[0]` for every clock of the access. On an 8-bit bus the byte is always taken from `pad_din[7:0]`.
- R9: While `bus_off`=1, `pin_drive` and `ad_drive` are 0, and a request made while the bus is idle starts no access.
- R10: A request made while an access is running is ignored. The running access keeps its length and its address, and no second access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one phase per clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_table | input | 1 | 1 = table byte read, 0 = instruction fetch |
| req_ptr | input | 21 | Byte pointer |
| cfg_narrow | input | 1 | 1 = 8-bit bus, 0 = 16-bit multiplexed bus |
| cfg_wait | input | 2 | Wait code for table reads (3 - extra cycles) |
| bus_off | input | 1 | Releases all bus drivers, blocks new accesses |
| pad_din | input | 16 | Read data from the pads |
| ad_out | output | 16 | Address value for the shared address/data pins |
| ad_drive | output | 1 | Output enable for the shared pins |
| addr_hi | output | 4 | High address pins |
| ale | output | 1 | Address latch strobe |
| oe_n | output | 1 | Active-low read strobe |
| ba0 | output | 1 | Byte-address pin |
| pin_drive | output | 1 | Output enable for the control and high address pins |
| done | output | 1 | One-clock completion flag |
| rd_word | output | 16 | Fetched instruction word |
| rd_byte | output | 8 | Table read byte |

## Verification
The completion flag of one access and the acceptance of the next request can fall in the same clock. The bench sets up this overlap by raising a new request in the very clock where `done` is seen high. It then checks that the following clock is a clean Q1 with the new address, and that the result registers still hold the earlier access's value. A second overlap places a request in the middle of a running access. The reference model judges it by the unchanged access length and by the absence of any later address strobe.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int PTR_W  = 21;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int HI_W   = PTR_W - 1 - DATA_W;
    localparam int WC_W   = 2;

    typedef enum logic {
        ACC_FETCH = 1'b0,
        ACC_TABLE = 1'b1
    } acc_kind_e;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic               narrow;
        logic [PTR_W-1:0]   ptr;
    } acc_req_t;

    // wait code 3 -> 0 extra cycles ... code 0 -> 3 extra cycles
    function automatic logic [WC_W-1:0] extra_cycles(input logic [WC_W-1:0] code);
        return ~code;
    endfunction

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WC_W-1:0]  extra,
    output logic             active,
    output phase_e           phase,
    output logic             first,
    output logic             finish
);

    logic [WC_W-1:0] cyc;
    logic [WC_W-1:0] ncyc;
    logic [1:0]      ph_nxt;

    assign ph_nxt = phase + 2'd1;
    assign first  = (cyc == '0);
    assign finish = active && (phase == PH_Q4) && (cyc == ncyc);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= PH_Q1;
            cyc    <= '0;
            ncyc   <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                phase  <= PH_Q1;
                cyc    <= '0;
                ncyc   <= extra;
            end
        end else begin
            phase <= phase_e'(ph_nxt);
            if (phase == PH_Q4) begin
                if (cyc == ncyc) active <= 1'b0;
                else             cyc    <= cyc + 1'b1;
            end
        end
    end

    // R6: the access ends right after its final phase
    p_finish_idle_r6: assert property (@(posedge clk) disable iff (rst)
        finish |=> !active);

    // R3: phases advance one per clock while an access runs
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (phase == phase_e'($past(phase) + 2'd1)));

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  phase_e            phase,
    input  logic              first,
    input  acc_req_t          cur,
    input  logic              bus_off,
    output logic              ale,
    output logic              ad_drive,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   addr_hi,
    output logic              oe_n,
    output logic              ba0
);

    logic rd_window;
    logic tbl_on;

    assign ale       = active && first && (phase == PH_Q1);
    assign ad_drive  = ale && !bus_off;
    assign ad_out    = ale ? cur.ptr[DATA_W:1] : '0;
    assign addr_hi   = active ? cur.ptr[PTR_W-1:DATA_W+1] : '0;
    assign rd_window = active && (!first || (phase == PH_Q3) || (phase == PH_Q4));
    assign oe_n      = !rd_window;
    assign tbl_on    = active && (cur.kind == ACC_TABLE);

    always_comb begin
        ba0 = 1'b0;
        if (tbl_on)
            ba0 = cur.ptr[0];
        else if (active && cur.narrow)
            ba0 = (phase == PH_Q4);
    end

    // R2: shared pins are driven only under the address strobe
    p_ad_under_ale_r2: assert property (@(posedge clk) disable iff (rst)
        ad_drive |-> ale);

    // R3: strobe and read enable never overlap
    p_ale_oe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> oe_n);

    // R8: byte address is fixed across a table read
    p_tbl_ba0_r8: assert property (@(posedge clk) disable iff (rst)
        (tbl_on && $past(tbl_on)) |-> $stable(ba0));

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  phase_e            phase,
    input  logic              finish,
    input  logic              is_table,
    input  logic              narrow,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] pad_din,
    output logic              done,
    output logic [DATA_W-1:0] rd_word,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0] lo_hold;
    logic [BYTE_W-1:0] lane_sel;

    assign lane_sel = (narrow || !lane_hi) ? pad_din[BYTE_W-1:0]
                                           : pad_din[DATA_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            rd_word <= '0;
            rd_byte <= '0;
            lo_hold <= '0;
        end else begin
            done <= finish;
            if (active && !is_table && narrow && (phase == PH_Q3))
                lo_hold <= pad_din[BYTE_W-1:0];
            if (finish) begin
                if (is_table)
                    rd_byte <= lane_sel;
                else if (narrow)
                    rd_word <= {pad_din[BYTE_W-1:0], lo_hold};
                else
                    rd_word <= pad_din;
            end
        end
    end

    // R4: completion is a single-clock pulse
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_table,
    input  logic [20:0]       req_ptr,
    input  logic              cfg_narrow,
    input  logic [1:0]        cfg_wait,
    input  logic              bus_off,
    input  logic [15:0]       pad_din,
    output logic [15:0]       ad_out,
    output logic              ad_drive,
    output logic [3:0]        addr_hi,
    output logic              ale,
    output logic              oe_n,
    output logic              ba0,
    output logic              pin_drive,
    output logic              done,
    output logic [15:0]       rd_word,
    output logic [7:0]        rd_byte
);

    acc_req_t         cur;
    logic             busy;
    logic             start;
    logic             first;
    logic             finish;
    phase_e           phase;
    logic [WC_W-1:0]  extra;

    assign start     = req_valid && !busy && !bus_off;
    assign extra     = req_table ? extra_cycles(cfg_wait) : '0;
    assign pin_drive = !bus_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (start) begin
            cur.kind   <= req_table ? ACC_TABLE : ACC_FETCH;
            cur.narrow <= cfg_narrow;
            cur.ptr    <= req_ptr;
        end
    end

    xbus_phase i_phase (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .extra  (extra),
        .active (busy),
        .phase  (phase),
        .first  (first),
        .finish (finish)
    );

    xbus_drive i_drive (
        .clk      (clk),
        .rst      (rst),
        .active   (busy),
        .phase    (phase),
        .first    (first),
        .cur      (cur),
        .bus_off  (bus_off),
        .ale      (ale),
        .ad_drive (ad_drive),
        .ad_out   (ad_out),
        .addr_hi  (addr_hi),
        .oe_n     (oe_n),
        .ba0      (ba0)
    );

    xbus_capture i_capture (
        .clk      (clk),
        .rst      (rst),
        .active   (busy),
        .phase    (phase),
        .finish   (finish),
        .is_table (cur.kind == ACC_TABLE),
        .narrow   (cur.narrow),
        .lane_hi  (cur.ptr[0]),
        .pad_din  (pad_din),
        .done     (done),
        .rd_word  (rd_word),
        .rd_byte  (rd_byte)
    );

    // R9: an idle bus stays idle while released
    p_idle_off_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_off && !busy) |=> !busy);

    // R4: completion coincides with the read strobe rising
    p_done_oe_rise_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (oe_n && $past(!oe_n)));

    // R10: no new strobe while an access runs past Q1
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !first) |-> !ale);

endmodule

// File: tb/test_xbus_seq.sv
module test_xbus_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_table, cfg_narrow, bus_off;
    logic [20:0] req_ptr;
    logic [1:0]  cfg_wait;
    logic [15:0] pad_din;
    logic [15:0] ad_out, rd_word;
    logic [3:0]  addr_hi;
    logic [7:0]  rd_byte;
    logic        ad_drive, ale, oe_n, ba0, pin_drive, done;

    always #10 clk = ~clk;

    xbus_seq i_xbus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_table(req_table),
        .req_ptr(req_ptr), .cfg_narrow(cfg_narrow), .cfg_wait(cfg_wait),
        .bus_off(bus_off), .pad_din(pad_din), .ad_out(ad_out),
        .ad_drive(ad_drive), .addr_hi(addr_hi), .ale(ale), .oe_n(oe_n),
        .ba0(ba0), .pin_drive(pin_drive), .done(done), .rd_word(rd_word),
        .rd_byte(rd_byte)
    );

    int n_chk = 0;
    int n_bad = 0;
    int k = 0;
    bit cmp_on = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_busy, m_done, m_table, m_narrow;
    int          m_t, m_len;
    logic [20:0] m_ptr;
    logic [15:0] m_word;
    logic [7:0]  m_byte, m_lo;

    always @(posedge clk) begin
        cmp_on <= 1'b1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_word = '0; m_byte = '0; m_lo = '0;
            m_t = 0; m_len = 0; m_ptr = '0; m_table = 0; m_narrow = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (!m_table && m_narrow && m_t == 2) m_lo = pad_din[7:0];
                if (m_t == m_len - 1) begin
                    m_busy = 0;
                    m_done = 1;
                    if (!m_table)
                        m_word = m_narrow ? {pad_din[7:0], m_lo} : pad_din;
                    else
                        m_byte = (m_narrow || !m_ptr[0]) ? pad_din[7:0] : pad_din[15:8];
                end else begin
                    m_t++;
                end
            end else if (req_valid && !bus_off) begin
                m_busy = 1; m_t = 0;
                m_table = req_table; m_narrow = cfg_narrow; m_ptr = req_ptr;
                m_len = req_table ? 4 * (4 - int'(cfg_wait)) : 4;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            logic e_ale;
            e_ale = m_busy && (m_t == 0);
            chk("R2 ale", ale, e_ale);
            chk("R2 ad_drive", ad_drive, e_ale && !bus_off);
            chk("R2 ad_out", ad_out, e_ale ? m_ptr[16:1] : 16'h0);
            chk("R2 addr_hi", addr_hi, m_busy ? m_ptr[20:17] : 4'h0);
            chk("R3 oe_n", oe_n, !(m_busy && m_t >= 2));
            chk("R7/R8 ba0", ba0, m_busy ? (m_table ? m_ptr[0] : (m_narrow && m_t == 3)) : 1'b0);
            chk("R4/R6 done", done, m_done);
            chk("R4/R7 rd_word", rd_word, m_word);
            chk("R5/R8 rd_byte", rd_byte, m_byte);
            chk("R9 pin_drive", pin_drive, !bus_off);
        end
        #1;
        k++;
        pad_din = 16'h1A2B + 16'(k * 16'h0F31);
    end

    task automatic do_req(input bit tbl, input logic [20:0] ptr, input bit nar,
                          input logic [1:0] wc, input int exp_len, input bit b2b,
                          input string tag);
        int n;
        if (!b2b) begin
            @(negedge clk); #2;
        end
        req_valid = 1; req_table = tbl; req_ptr = ptr; cfg_narrow = nar; cfg_wait = wc;
        n = 0;
        do begin
            @(negedge clk); #2;
            if (n == 0) req_valid = 0;
            n++;
        end while (!done && n < 100);
        chk(tag, n, exp_len + 1);
    endtask

    initial begin
        rst = 1; req_valid = 0; req_table = 0; req_ptr = '0; cfg_narrow = 0;
        cfg_wait = 2'b00; bus_off = 0; pad_din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 ale", ale, 0);
        chk("R1 oe_n", oe_n, 1);
        chk("R1 done", done, 0);
        chk("R1 rd_word", rd_word, 0);
        #2 rst = 0;

        do_req(0, 21'h0A_BCDE, 0, 2'b00, 4,  0, "R4 fetch16 length");
        do_req(0, 21'h1F_0001, 0, 2'b11, 4,  0, "R6 fetch ignores wait");
        do_req(1, 21'h03_4560, 0, 2'b11, 4,  0, "R5 table lo lane");
        do_req(1, 21'h12_3457, 0, 2'b00, 16, 0, "R6 table 3 waits");
        do_req(1, 21'h00_0011, 0, 2'b10, 8,  0, "R6 table 1 wait");
        do_req(1, 21'h15_5555, 0, 2'b01, 12, 0, "R6 table 2 waits");
        do_req(0, 21'h0C_3A18, 1, 2'b00, 4,  0, "R7 narrow fetch");
        do_req(1, 21'h07_7777, 1, 2'b11, 4,  0, "R8 narrow table odd");
        // completion and new request in the same clock
        do_req(1, 21'h1E_0003, 0, 2'b11, 4,  1, "R5 back to back");
        do_req(0, 21'h02_4682, 1, 2'b00, 4,  1, "R7 back to back");

        // R10: request in the middle of an access
        fork
            do_req(1, 21'h09_1357, 0, 2'b01, 12, 0, "R10 length kept");
            begin
                repeat (6) @(negedge clk);
                #3; req_valid = 1; req_ptr = 21'h1F_FFFF; req_table = 0;
                @(negedge clk); #3; req_valid = 0;
            end
        join
        repeat (6) begin
            @(negedge clk);
            chk("R10 no late start", ale, 0);
        end

        // R9: released bus ignores requests
        @(negedge clk); #2;
        bus_off = 1; req_valid = 1; req_ptr = 21'h0F_0F0F;
        @(negedge clk); #2; req_valid = 0;
        repeat (8) begin
            @(negedge clk);
            chk("R9 no access", oe_n, 1);
            chk("R9 no done", done, 0);
            chk("R9 ad released", ad_drive, 0);
        end
        #2 bus_off = 0;
        do_req(1, 21'h01_2345, 0, 2'b11, 4, 0, "R9 resumes");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule